// File: doc/BRIEF.md
# Decode Issue Interlock

This block sits at the head of the decode stage of an in-order pipeline that has no forwarding paths. In every cycle it decides whether the decoded instruction may move into the execute unit. It holds one pending-write bit for each architectural register. The bit is set when an instruction that writes that register issues. It is cleared when the writeback stage reports the write.

The instruction stays in decode in three cases:
- a source register it reads has a pending write,
- its own destination still has a pending write,
- the execute unit reports that it is busy.

The register file is written in the first half of a cycle and read in the second half. A register that is being written back in the current cycle therefore does not cause a stall. The stall ends in the writeback cycle itself. Register 0 is a constant. It is never marked pending and never causes a hold.

Top module: `dec_issue_gate`

## Requirements
- R1: After reset no register is pending, so any valid instruction issues while the execute unit is idle.
- R2: A valid instruction whose first source is in use and names a pending register (not 0) is held: `issue` is 0 and `hold_data` is 1.
- R3: The same hold as in R2 applies to the second source when it is in use.
- R4: Register 0 is never marked pending and never causes a hold, whether it appears as a source or as a destination.
- R5: A writeback to a register in the same cycle releases a hold on that register, so the dependent instruction issues in the writeback cycle.
- R6: When `ex_busy` is 1, `issue` is 0 and `hold_struct` is 1 for a valid instruction, whatever its register dependences.
- R7: When `dec_valid` is 0, `issue` is 0 and no register becomes pending.
- R8: A register becomes pending in the cycle after an issue with `dst_writes`=1 and a nonzero `dst`. An issue with `dst_writes`=0 (a store or a branch) marks nothing.
- R9: If an issue and a writeback name the same register in the same cycle, the register is pending afterwards.
- R10: A valid instruction whose destination is already pending (and is not being written back in this cycle) is held with `hold_data`=1.
- R11: A source field whose use flag is 0 is ignored.
- R12: A writeback clears only the register it names. Other pending registers stay pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode holds a valid instruction |
| src_a_used | input | 1 | First source register is read |
| src_a | input | 5 | First source register number |
| src_b_used | input | 1 | Second source register is read |
| src_b | input | 5 | Second source register number |
| dst_writes | input | 1 | Instruction writes a register |
| dst | input | 5 | Destination register number |
| ex_busy | input | 1 | Execute unit cannot accept an instruction |
| wb_valid | input | 1 | Writeback writes a register in this cycle |
| wb_reg | input | 5 | Register written by writeback |
| issue | output | 1 | Instruction moves to execute at this edge |
| hold_data | output | 1 | Valid instruction held by a register dependence |
| hold_struct | output | 1 | Valid instruction held by a busy execute unit |

## Verification
The assertions assume two things about the rest of the pipeline. First, writeback only reports registers that an earlier issue marked. Second, the decode inputs stay put while `issue` is low. The pending checks also assume that writeback never targets register 0 when it matters.

The stimulus follows a realistic order. Each writeback it drives names a register left pending by an earlier vector, so clearing is always observed on a bit that was really set. Dependent reads are placed one vector after their producer and again in the writeback cycle, so both the held cycle and the release cycle are sampled.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    localparam int DEF_NUM_REGS = 32;

    // Reason the decode slot did not issue this cycle
    typedef enum logic [1:0] {
        SLOT_GO    = 2'd0,
        SLOT_EMPTY = 2'd1,
        SLOT_DATA  = 2'd2,
        SLOT_EXEC  = 2'd3
    } slot_state_t;

    // A register reference counts only when flagged and not the zero register
    function automatic logic live_ref(input logic used, input logic [7:0] idx);
        return used && (idx != 8'd0);
    endfunction

endpackage

// File: rtl/pending_table.sv
module pending_table #(
    parameter int NREG = 32,
    localparam int IW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_en,
    input  logic [IW-1:0]   set_idx,
    input  logic            clr_en,
    input  logic [IW-1:0]   clr_idx,
    output logic [NREG-1:0] pend
);

    assign pend[0] = 1'b0;

    for (genvar r = 1; r < NREG; r++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (set_en && (set_idx == IW'(r))) begin
                bit_q <= 1'b1;
            end else if (clr_en && (clr_idx == IW'(r))) begin
                bit_q <= 1'b0;
            end
        end
        assign pend[r] = bit_q;
    end

    // R8
    mark_on_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (set_en && set_idx != '0) |=> pend[$past(set_idx)]);

    // R12
    clear_on_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> !pend[$past(clr_idx)]);

    // R9
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (set_en && clr_en && set_idx == clr_idx && set_idx != '0) |=> pend[$past(set_idx)]);

endmodule

// File: rtl/hazard_check.sv
module hazard_check #(
    parameter int NREG = 32,
    localparam int IW = $clog2(NREG)
) (
    input  logic [NREG-1:0] pend,
    input  logic            a_used,
    input  logic [IW-1:0]   a_idx,
    input  logic            b_used,
    input  logic [IW-1:0]   b_idx,
    input  logic            d_writes,
    input  logic [IW-1:0]   d_idx,
    input  logic            wb_en,
    input  logic [IW-1:0]   wb_idx,
    output logic            raw_hit,
    output logic            waw_hit
);
    import ilk_pkg::*;

    // Pending and not released by a write in the first half of this cycle
    function automatic logic still_pending(input logic [IW-1:0] idx);
        return pend[idx] && !(wb_en && wb_idx == idx);
    endfunction

    logic a_live, b_live, d_live;

    always_comb begin
        a_live  = live_ref(a_used, 8'(a_idx));
        b_live  = live_ref(b_used, 8'(b_idx));
        d_live  = live_ref(d_writes, 8'(d_idx));
        raw_hit = (a_live && still_pending(a_idx)) ||
                  (b_live && still_pending(b_idx));
        waw_hit = d_live && still_pending(d_idx);
    end

endmodule

// File: rtl/dec_issue_gate.sv
module dec_issue_gate #(
    parameter int NREG = 32,
    localparam int IW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dec_valid,
    input  logic          src_a_used,
    input  logic [IW-1:0] src_a,
    input  logic          src_b_used,
    input  logic [IW-1:0] src_b,
    input  logic          dst_writes,
    input  logic [IW-1:0] dst,
    input  logic          ex_busy,
    input  logic          wb_valid,
    input  logic [IW-1:0] wb_reg,
    output logic          issue,
    output logic          hold_data,
    output logic          hold_struct
);
    import ilk_pkg::*;

    logic [NREG-1:0] pend;
    logic            raw_hit, waw_hit;
    logic            mark_en;
    slot_state_t     slot;

    hazard_check #(.NREG(NREG)) u_check (
        .pend(pend),
        .a_used(src_a_used), .a_idx(src_a),
        .b_used(src_b_used), .b_idx(src_b),
        .d_writes(dst_writes), .d_idx(dst),
        .wb_en(wb_valid), .wb_idx(wb_reg),
        .raw_hit(raw_hit), .waw_hit(waw_hit)
    );

    always_comb begin
        if (!dec_valid)             slot = SLOT_EMPTY;
        else if (raw_hit || waw_hit) slot = SLOT_DATA;
        else if (ex_busy)           slot = SLOT_EXEC;
        else                        slot = SLOT_GO;
    end

    assign issue       = (slot == SLOT_GO);
    assign hold_data   = (slot == SLOT_DATA);
    assign hold_struct = dec_valid && ex_busy;
    assign mark_en     = issue && live_ref(dst_writes, 8'(dst));

    pending_table #(.NREG(NREG)) u_table (
        .clk(clk), .rst(rst),
        .set_en(mark_en), .set_idx(dst),
        .clr_en(wb_valid), .clr_idx(wb_reg),
        .pend(pend)
    );

    // R6
    busy_blocks_issue_chk: assert property (@(posedge clk) disable iff (rst)
        ex_busy |-> !issue);

    // R7
    empty_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> !issue);

    // R4
    zero_never_pending_chk: assert property (@(posedge clk) disable iff (rst)
        !pend[0]);

endmodule

// File: tb/test_dec_issue_gate.sv
module test_dec_issue_gate;
    localparam int CLK_PER = 10;

    typedef struct packed {
        logic       v;
        logic       ua;
        logic [4:0] a;
        logic       ub;
        logic [4:0] b;
        logic [4:0] d;
        logic       w;
        logic       busy;
        logic       wbv;
        logic [4:0] wbr;
        logic       exp_issue;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b1,5'd1, 1'b1,5'd2, 5'd3, 1'b1,1'b0,1'b0,5'd0, 1'b1,4'd1},  // R1 issue r3
        '{1'b1,1'b1,5'd3, 1'b1,5'd1, 5'd4, 1'b1,1'b0,1'b0,5'd0, 1'b0,4'd2},  // R2 A reads r3
        '{1'b1,1'b1,5'd1, 1'b1,5'd3, 5'd5, 1'b1,1'b0,1'b0,5'd0, 1'b0,4'd3},  // R3 B reads r3
        '{1'b1,1'b1,5'd3, 1'b1,5'd1, 5'd4, 1'b1,1'b0,1'b1,5'd3, 1'b1,4'd5},  // R5 wb r3 same cycle
        '{1'b1,1'b1,5'd1, 1'b0,5'd4, 5'd6, 1'b1,1'b0,1'b0,5'd0, 1'b1,4'd11}, // R11 unused B=r4
        '{1'b1,1'b1,5'd1, 1'b1,5'd2, 5'd4, 1'b1,1'b0,1'b0,5'd0, 1'b0,4'd10}, // R10 dst r4 pending
        '{1'b1,1'b1,5'd0, 1'b1,5'd0, 5'd0, 1'b1,1'b0,1'b0,5'd0, 1'b1,4'd4},  // R4 write r0
        '{1'b1,1'b1,5'd0, 1'b1,5'd0, 5'd7, 1'b1,1'b0,1'b0,5'd0, 1'b1,4'd4},  // R4 read r0
        '{1'b1,1'b1,5'd1, 1'b1,5'd2, 5'd8, 1'b1,1'b1,1'b0,5'd0, 1'b0,4'd6},  // R6 busy
        '{1'b0,1'b1,5'd1, 1'b1,5'd2, 5'd9, 1'b1,1'b0,1'b0,5'd0, 1'b0,4'd7},  // R7 slot empty
        '{1'b1,1'b1,5'd9, 1'b1,5'd9, 5'd10,1'b1,1'b0,1'b0,5'd0, 1'b1,4'd7},  // R7 r9 not marked
        '{1'b1,1'b1,5'd1, 1'b1,5'd2, 5'd11,1'b0,1'b0,1'b0,5'd0, 1'b1,4'd8},  // R8 store-like
        '{1'b1,1'b1,5'd11,1'b1,5'd11,5'd12,1'b0,1'b0,1'b0,5'd0, 1'b1,4'd8},  // R8 r11 not marked
        '{1'b1,1'b1,5'd7, 1'b0,5'd0, 5'd0, 1'b0,1'b0,1'b1,5'd6, 1'b0,4'd12}, // R12 wb r6, r7 held
        '{1'b1,1'b1,5'd6, 1'b1,5'd1, 5'd0, 1'b0,1'b0,1'b0,5'd0, 1'b1,4'd12}, // R12 r6 cleared
        '{1'b1,1'b1,5'd1, 1'b1,5'd2, 5'd10,1'b1,1'b0,1'b1,5'd10,1'b1,4'd9},  // R9 issue+wb r10
        '{1'b1,1'b1,5'd10,1'b0,5'd0, 5'd0, 1'b0,1'b0,1'b0,5'd0, 1'b0,4'd9},  // R9 r10 pending
        '{1'b1,1'b1,5'd10,1'b0,5'd0, 5'd0, 1'b0,1'b0,1'b1,5'd10,1'b1,4'd5}   // R5 release r10
    };

    logic clk = 1'b0;
    logic rst;
    logic dec_valid, src_a_used, src_b_used, dst_writes, ex_busy, wb_valid;
    logic [4:0] src_a, src_b, dst, wb_reg;
    logic issue, hold_data, hold_struct;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    dec_issue_gate i_dec_issue_gate (
        .clk(clk), .rst(rst), .dec_valid(dec_valid),
        .src_a_used(src_a_used), .src_a(src_a),
        .src_b_used(src_b_used), .src_b(src_b),
        .dst_writes(dst_writes), .dst(dst), .ex_busy(ex_busy),
        .wb_valid(wb_valid), .wb_reg(wb_reg),
        .issue(issue), .hold_data(hold_data), .hold_struct(hold_struct)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t x);
        @(negedge clk);
        dec_valid = x.v; src_a_used = x.ua; src_a = x.a;
        src_b_used = x.ub; src_b = x.b; dst = x.d; dst_writes = x.w;
        ex_busy = x.busy; wb_valid = x.wbv; wb_reg = x.wbr;
        #2;
    endtask

    initial begin
        rst = 1'b1;
        drive('{1'b0,1'b0,5'd0,1'b0,5'd0,5'd0,1'b0,1'b0,1'b0,5'd0,1'b0,4'd0});
        @(negedge clk);
        rst = 1'b0;
        // R1 idle slot after reset
        check("R1 idle issue", issue, 1'b0);
        check("R1 idle hold_data", hold_data, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            check($sformatf("R%0d vec %0d issue", VEC[i].req, i), issue, VEC[i].exp_issue);
            if (VEC[i].req == 4'd2 || VEC[i].req == 4'd3 || VEC[i].req == 4'd10)
                check($sformatf("R%0d vec %0d hold_data", VEC[i].req, i), hold_data, 1'b1);
            if (VEC[i].req == 4'd6) begin
                check("R6 hold_struct", hold_struct, 1'b1);
                check("R6 no hold_data", hold_data, 1'b0);
            end
        end

        // R6 busy overrides a clean instruction reading r0 only
        drive('{1'b1,1'b1,5'd0,1'b1,5'd0,5'd0,1'b0,1'b1,1'b0,5'd0,1'b0,4'd6});
        check("R6 busy, no deps", issue, 1'b0);
        check("R6 hold_struct", hold_struct, 1'b1);

        // R1 reset clears pending r4,r7 marks
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        drive('{1'b1,1'b1,5'd4,1'b1,5'd7,5'd10,1'b1,1'b0,1'b0,5'd0,1'b1,4'd1});
        check("R1 pending cleared by reset", issue, 1'b1);
        check("R1 no hold after reset", hold_data, 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule